// File: doc/BRIEF.md
# Addressed Two-Word Serial Response Transmitter

This block is the reply side of a remote station on a shared serial line. The receiver next to it reports when the station's own address has arrived and when the following command word has ended. After that, a rising edge on the send input starts a reply of two back-to-back 11-bit words. The first word carries an identification byte and the second a status byte. Both bytes come from parallel inputs, and each byte is captured at a fixed point in the frame.

Bit timing comes from a free-running divider of `DIV` clocks per bit, which the receiver shares. A reply always starts its first start bit on a half-bit phase point of that divider. The serial output is inverted, so that an external inverting driver can put normal polarity on the line. The reply is only sent when the station was addressed, and the send edge must arrive within a bounded window after the command strobe.

Top module: `resp_tx`

## Requirements
- R1: A rising edge on `send_i` starts a reply only if `addr_valid_i` was pulsed and a later `cmd_strobe_i` pulse then opened the send window. A send edge with no address, or with an address but no command strobe, produces no output activity.
- R2: The send window lasts `WIN_BITS*DIV` clocks after the command strobe. A send edge inside it is accepted. A send edge after it is ignored, and expiry also clears the address-valid state.
- R3: A reply is two 11-bit words sent with no gap. Each word is, in time order: a start bit at index 0, eight data bits at indices 1..8 least significant bit first, a parity bit at index 9 and a stop bit at index 10. Each bit lasts `DIV` clocks.
- R4: The parity bit is the XOR of the eight data bits, so the count of ones over data and parity is even.
- R5: The first word's data is `id_i` as sampled one clock before its start bit. The second word's data is `status_i` as sampled at the clock edge that begins the second start bit. Later changes have no effect on the frame.
- R6: `tx_o` is the inverse of line polarity. It is 0 when idle and 1 during a start bit. A data or parity bit of value b is driven as !b, and a stop bit is driven as 0.
- R7: The first start bit begins between 2 and `DIV/2+2` clocks after the send edge. It always falls on a multiple of `DIV/2` clocks of the shared divider, so all replies keep the same phase modulo `DIV/2`.
- R8: A send edge while a reply is in progress is ignored. When a reply ends, the address-valid and window states are cleared, so a further send edge needs a fresh address and command strobe.
- R9: `busy_o` rises one clock after the accepted send edge. It falls exactly `22*DIV` clocks after the first start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid_i | input | 1 | One-clock pulse: the station's address was received |
| cmd_strobe_i | input | 1 | One-clock pulse: the command word has ended |
| send_i | input | 1 | Reply trigger, rising-edge sensitive |
| id_i | input | 8 | Identification byte for the first word |
| status_i | input | 8 | Status byte for the second word |
| tx_o | output | 1 | Inverted serial output |
| busy_o | output | 1 | High from an accepted send until the reply ends |

## Verification
The bench builds the block with `DIV=16` and `WIN_BITS=7`. With these values a full reply takes 352 clocks and the send window is 112 clocks. Several complete frames, an on-time send near the end of the window and a late send after it all fit in a short run. The short bit period also makes the half-bit phase rule easy to check: every start-bit onset must land on the same residue modulo 8 of the bench's own clock count, while the launch latency varies with where each send edge falls.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BITS  = BYTE_W + 3;
    localparam int IDX_W      = $clog2(WORD_BITS);
    localparam int PAR_IDX    = BYTE_W + 1;
    localparam int STOP_IDX   = BYTE_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_SEND   = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             second;
    } frame_pos_t;

    // Line-polarity level of bit position idx within a word holding d.
    function automatic logic frame_level(input logic [BYTE_W-1:0] d,
                                         input logic [IDX_W-1:0]  idx);
        logic lvl;
        if (idx == '0)
            lvl = 1'b0;
        else if (int'(idx) <= BYTE_W)
            lvl = d[int'(idx) - 1];
        else if (int'(idx) == PAR_IDX)
            lvl = ^d;
        else
            lvl = 1'b1;
        return lvl;
    endfunction

endpackage

// File: rtl/resp_tx_bitclk.sv
module resp_tx_bitclk #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic pre_o,
    output logic point_o
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // pre_o: two clocks ahead of a phase point (capture, then launch)
    assign pre_o   = (cnt_q == CW'(HALF - 2)) || (cnt_q == CW'(DIV - 2));
    assign point_o = (cnt_q == '0) || (cnt_q == CW'(HALF));

    p_point_follows_pre_r7: assert property (@(posedge clk) disable iff (rst)
        pre_o |=> ##1 point_o);

endmodule

// File: rtl/resp_tx_gate.sv
module resp_tx_gate #(
    parameter int DIV      = 64,
    parameter int WIN_BITS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_valid_i,
    input  logic cmd_strobe_i,
    input  logic send_i,
    input  logic busy_i,
    input  logic done_i,
    output logic accept_o
);
    localparam int WIN_CYC = DIV * WIN_BITS;
    localparam int WW      = $clog2(WIN_CYC + 1);

    logic          send_q;
    logic          val_q;
    logic          sel_q;
    logic [WW-1:0] win_q;
    logic          send_rise;
    logic          counting;
    logic          expire;

    assign send_rise = send_i && !send_q;
    assign accept_o  = send_rise && sel_q && !busy_i;
    assign counting  = sel_q && !busy_i && !accept_o;
    assign expire    = counting && (win_q == WW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            send_q <= 1'b0;
            val_q  <= 1'b0;
            sel_q  <= 1'b0;
            win_q  <= '0;
        end else begin
            send_q <= send_i;
            if (done_i || expire) begin
                val_q <= 1'b0;
                sel_q <= 1'b0;
                win_q <= '0;
            end else begin
                if (addr_valid_i && !busy_i)
                    val_q <= 1'b1;
                if (cmd_strobe_i && val_q && !busy_i) begin
                    sel_q <= 1'b1;
                    win_q <= WW'(WIN_CYC);
                end else if (counting) begin
                    win_q <= win_q - 1'b1;
                end
            end
        end
    end

    p_sel_implies_val_r1: assert property (@(posedge clk) disable iff (rst)
        sel_q |-> val_q);
    p_cleared_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_i |=> (!val_q && !sel_q));
    p_expiry_closes_r2: assert property (@(posedge clk) disable iff (rst)
        expire |=> !sel_q);

endmodule

// File: rtl/resp_tx_ser.sv
module resp_tx_ser
    import resp_tx_pkg::*;
#(
    parameter int DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              pre_i,
    input  logic              point_i,
    input  logic [BYTE_W-1:0] id_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int TW = $clog2(DIV);

    tx_state_e         state_q;
    frame_pos_t        pos_q;
    logic [TW-1:0]     tmr_q;
    logic [BYTE_W-1:0] data_q;
    logic              tx_q;
    logic              bit_end;
    logic              word_end;
    logic [IDX_W-1:0]  idx_nx;

    assign bit_end  = (state_q == ST_SEND) && (tmr_q == TW'(DIV - 1));
    assign word_end = bit_end && (pos_q.idx == IDX_W'(STOP_IDX));
    assign done_o   = word_end && pos_q.second;
    assign idx_nx   = pos_q.idx + 1'b1;
    assign busy_o   = (state_q != ST_IDLE);
    assign tx_o     = tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            tmr_q   <= '0;
            data_q  <= '0;
            tx_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_i)
                        state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (pre_i) begin
                        data_q  <= id_i;
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    state_q <= ST_SEND;
                    pos_q   <= '0;
                    tmr_q   <= '0;
                    tx_q    <= 1'b1;
                end
                default: begin
                    if (bit_end) begin
                        tmr_q <= '0;
                        if (word_end) begin
                            if (!pos_q.second) begin
                                pos_q.second <= 1'b1;
                                pos_q.idx    <= '0;
                                data_q       <= status_i;
                                tx_q         <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                                pos_q   <= '0;
                                tx_q    <= 1'b0;
                            end
                        end else begin
                            pos_q.idx <= idx_nx;
                            tx_q      <= ~frame_level(data_q, idx_nx);
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            endcase
        end
    end

    p_idle_line_low_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !tx_q);
    p_launch_on_phase_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAUNCH) |=> point_i);
    p_index_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND) |-> (pos_q.idx <= IDX_W'(STOP_IDX)));
    p_start_driven_high_r6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SEND) && (tmr_q == '0) && (pos_q.idx == '0)) |-> tx_q);
    p_no_accept_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_WAIT) || $past(state_q == ST_WAIT));

endmodule

// File: rtl/resp_tx.sv
module resp_tx #(
    parameter int DIV      = 64,
    parameter int WIN_BITS = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_valid_i,
    input  logic       cmd_strobe_i,
    input  logic       send_i,
    input  logic [7:0] id_i,
    input  logic [7:0] status_i,
    output logic       tx_o,
    output logic       busy_o
);
    logic pre;
    logic point;
    logic accept;
    logic done;

    resp_tx_bitclk #(.DIV(DIV)) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .pre_o   (pre),
        .point_o (point)
    );

    resp_tx_gate #(.DIV(DIV), .WIN_BITS(WIN_BITS)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .addr_valid_i (addr_valid_i),
        .cmd_strobe_i (cmd_strobe_i),
        .send_i       (send_i),
        .busy_i       (busy_o),
        .done_i       (done),
        .accept_o     (accept)
    );

    resp_tx_ser #(.DIV(DIV)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .pre_i    (pre),
        .point_i  (point),
        .id_i     (id_i),
        .status_i (status_i),
        .tx_o     (tx_o),
        .busy_o   (busy_o),
        .done_o   (done)
    );

    p_busy_rises_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);

endmodule

// File: tb/resp_tx_tb.sv
module resp_tx_tb;
    localparam int DIV  = 16;
    localparam int HALF = DIV / 2;
    localparam int WINB = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_valid_i = 1'b0;
    logic       cmd_strobe_i = 1'b0;
    logic       send_i = 1'b0;
    logic [7:0] id_i = 8'h00;
    logic [7:0] status_i = 8'h00;
    logic       tx_o;
    logic       busy_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int phase_ref = -1;
    bit finished = 1'b0;

    resp_tx #(.DIV(DIV), .WIN_BITS(WINB)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr_valid_i (addr_valid_i),
        .cmd_strobe_i (cmd_strobe_i),
        .send_i       (send_i),
        .id_i         (id_i),
        .status_i     (status_i),
        .tx_o         (tx_o),
        .busy_o       (busy_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_addr();
        @(negedge clk); addr_valid_i = 1'b1;
        @(negedge clk); addr_valid_i = 1'b0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_strobe_i = 1'b1;
        @(negedge clk); cmd_strobe_i = 1'b0;
    endtask

    task automatic send_rise();
        @(negedge clk); send_i = 1'b0;
        @(negedge clk); send_i = 1'b1;
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_o || busy_o) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // Send a reply and check every bit of it.
    task automatic fire_frame(input logic [7:0] id_a, input logic [7:0] id_b,
                              input logic [7:0] st_a, input logic [7:0] st_b,
                              input logic [7:0] st_c, input bit poke);
        int lat;
        int rise;
        logic [21:0] bits;
        bit busy_pre;
        bit busy_post;
        bit tx_post;
        @(negedge clk);
        id_i = id_a; status_i = st_a; send_i = 1'b0;
        @(negedge clk);
        send_i = 1'b1;
        @(negedge clk);
        lat = 1;
        chk(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
        id_i = id_b;
        while (!tx_o && lat < 3 * DIV) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= 2 && lat <= HALF + 2, "R7 launch latency", lat, HALF);
        rise = cyc;
        if (phase_ref < 0) phase_ref = rise % HALF;
        chk((rise % HALF) == phase_ref, "R7 phase residue", rise % HALF, phase_ref);
        busy_pre = 1'b0; busy_post = 1'b1; tx_post = 1'b1;
        for (int off = 0; off <= 22 * DIV; off++) begin
            if (off % DIV == HALF) bits[off / DIV] = tx_o;
            if (off == DIV) id_i = ~id_b;
            if (off == 5 * DIV) status_i = st_b;
            if (off == 11 * DIV + HALF) status_i = st_c;
            if (poke && off == 3 * DIV) send_i = 1'b0;
            if (poke && off == 3 * DIV + 2) send_i = 1'b1;
            if (off == 22 * DIV - 1) busy_pre = busy_o;
            if (off == 22 * DIV) begin
                busy_post = busy_o;
                tx_post = tx_o;
            end
            if (off < 22 * DIV) @(negedge clk);
        end
        chk(busy_pre == 1'b1, "R9 busy through last stop", busy_pre, 1);
        chk(busy_post == 1'b0, "R9 busy falls at 22 bits", busy_post, 0);
        chk(tx_post == 1'b0, "R6 idle low after reply", tx_post, 0);
        for (int w = 0; w < 2; w++) begin
            logic [7:0] d;
            logic [7:0] exp;
            exp = (w == 0) ? id_b : st_b;
            for (int k = 0; k < 8; k++) d[k] = ~bits[w * 11 + 1 + k];
            chk(bits[w * 11] == 1'b1, "R6 start driven high", bits[w * 11], 1);
            chk(d == exp, (w == 0) ? "R5 first word id byte" : "R5 second word status byte",
                d, exp);
            chk(~bits[w * 11 + 9] == ^exp, "R4 even parity", ~bits[w * 11 + 9], ^exp);
            chk(bits[w * 11 + 10] == 1'b0, "R3 stop bit", bits[w * 11 + 10], 0);
        end
        send_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(tx_o == 1'b0, "R6 reset tx low", tx_o, 0);
        chk(busy_o == 1'b0, "R9 reset not busy", busy_o, 0);
    endtask

    task automatic t_no_address();
        send_rise();
        expect_quiet(3 * DIV, "R1 send without address");
        send_i = 1'b0;
    endtask

    task automatic t_no_command();
        pulse_addr();
        idle(4);
        send_rise();
        expect_quiet(3 * DIV, "R1 send without command strobe");
        send_i = 1'b0;
    endtask

    task automatic t_normal();
        pulse_cmd();
        idle(2 * DIV);
        fire_frame(8'h5A, 8'hC3, 8'h11, 8'h96, 8'h0F, 1'b0);
    endtask

    task automatic t_late();
        pulse_addr();
        idle(3);
        pulse_cmd();
        idle(8 * DIV);
        send_rise();
        expect_quiet(3 * DIV, "R2 send after window");
        send_i = 1'b0;
        pulse_cmd();
        idle(2);
        send_rise();
        expect_quiet(3 * DIV, "R2 expiry cleared address");
        send_i = 1'b0;
    endtask

    task automatic t_window_edge();
        pulse_addr();
        idle(3);
        pulse_cmd();
        idle(6 * DIV);
        fire_frame(8'h01, 8'hFE, 8'h80, 8'h7F, 8'hAA, 1'b1);
    endtask

    task automatic t_after_end();
        idle(5);
        send_rise();
        expect_quiet(3 * DIV, "R8 latches cleared at end");
        send_i = 1'b0;
        pulse_cmd();
        idle(2);
        send_rise();
        expect_quiet(3 * DIV, "R8 no stale address");
        send_i = 1'b0;
    endtask

    task automatic t_third_phase();
        pulse_addr();
        idle(3);
        pulse_cmd();
        idle(DIV + 5);
        fire_frame(8'hFF, 8'h00, 8'h00, 8'hFF, 8'h3C, 1'b0);
    endtask

    initial begin
        idle(5);
        t_reset();
        @(negedge clk); rst = 1'b0;
        idle(3);
        t_no_address();
        t_no_command();
        t_normal();
        t_late();
        t_window_edge();
        t_after_end();
        t_third_phase();
        idle(5);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule